// File: doc/BRIEF.md
# Host serial front end with independent line polarity

This block is the host-facing serial port of a bridge that turns host characters into single-wire bus activity. It deserialises characters arriving on the host's transmit line and serialises response characters onto the host's receive line. Both use 8 data bits, no parity and the least significant bit first. Each bit is oversampled sixteen times. The start bit is confirmed at half a bit time, and data and stop bits are sampled at mid-bit. The bit rate comes from a two-bit speed code held in an internal configuration register. An engine reads the code only when it starts a character, so a rate change never disturbs a character already in flight.

A strap input sets the polarity of both lines. A separate configuration bit inverts only the outgoing line, so the two lines can have opposite senses. A received character whose stop position holds the start level is treated as a break. It produces a one-cycle master-reset pulse, returns the configuration to its defaults and aborts any transmission. After a power-on or master reset, the first good character is a calibration character: it is consumed and not presented to the command logic.

Top module: `hostlink_uart`

## Requirements
- R1: A received character is 8 data bits, least significant bit first, between a low start bit and a high stop bit (levels given after polarity correction). Its value appears on `rx_byte` together with a one-cycle `rx_strobe` during the stop bit.
- R2: Characters sent back to back with two stop bits each are all received correctly.
- R3: A transmitted character is one start bit, 8 data bits least significant bit first, and exactly one stop bit, each lasting one bit time. `tx_ready` stays low until the stop bit has ended.
- R4: With `pol_strap` = 1 both lines are true (idle high). With `pol_strap` = 0 both lines are inverted (idle low, data bits complemented).
- R5: Configuration bit `cfg_txinv` = 1 inverts only `host_rx_line`. The receive polarity still follows `pol_strap`.
- R6: A start-level sample in the stop-bit position raises `mreset_pulse` for exactly one clock. It clears the speed code and the invert bit.
- R7: Speed code 0, 1, 2 and 3 selects 9600, 19200, 57600 and 115200 bit/s respectively (divisor CLK_HZ/(16·rate) clocks per oversample tick).
- R8: After `rst_n` or a master reset the rate is 9600 bit/s and the outgoing line is not inverted.
- R9: The first good character after `rst_n` or a master reset produces no `rx_strobe`.
- R10: A low pulse on the incoming line shorter than half a bit time produces no character.
- R11: A configuration write during a transmitted character leaves that character at its original bit time. The next character uses the new rate.
- R12: A character is accepted only while `tx_ready` is high. A `tx_valid` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol_strap | input | 1 | Line polarity strap, 1 = true levels |
| host_tx_line | input | 1 | Serial line from the host |
| host_rx_line | output | 1 | Serial line to the host |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rate | input | 2 | Speed code written on `cfg_we` |
| cfg_txinv | input | 1 | Outgoing-line invert bit written on `cfg_we` |
| rx_byte | output | 8 | Last received character |
| rx_strobe | output | 1 | One-cycle pulse per delivered character |
| tx_byte | input | 8 | Character to transmit |
| tx_valid | input | 1 | Request to transmit `tx_byte` |
| tx_ready | output | 1 | Transmitter idle and able to accept |
| mreset_pulse | output | 1 | One-cycle master-reset request on break |

## Verification
The bench targets the calibration character that must be swallowed after each reset. A design that forwards it would hand a spurious command to the bridge. A second target is a break arriving while the rate is fast and the outgoing line is inverted. A design that treats it as a mere framing error would keep the stale rate and the inversion, and would then miss the following 9600 bit/s character.

Other directed cases probe the following:
- a glitch shorter than half a bit;
- two-stop-bit bursts, which a receiver that insists on a new start would lose;
- a configuration write in the middle of a transmitted character, which would stretch or shrink its later bits if the rate were not latched;
- a request while busy, which a careless handshake would turn into a second frame.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;

   typedef enum logic [1:0] {
      RATE_9K6   = 2'd0,
      RATE_19K2  = 2'd1,
      RATE_57K6  = 2'd2,
      RATE_115K2 = 2'd3
   } rate_e;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_HOLD
   } rx_state_e;

   typedef enum logic {
      TX_IDLE,
      TX_SEND
   } tx_state_e;

   // bit rate for each speed code
   function automatic int unsigned rate_bps(input int unsigned code);
      case (code)
         0:       return 9600;
         1:       return 19200;
         2:       return 57600;
         default: return 115200;
      endcase
   endfunction

endpackage

// File: rtl/hostlink_tick.sv
// Oversample tick generator: one tick every div_i clocks while not cleared.
module hostlink_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] pc_q;

   assign tick_o = !clr_i && (pc_q == div_i - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               pc_q <= '0;
      else if (clr_i || tick_o) pc_q <= '0;
      else                      pc_q <= pc_q + 1'b1;
   end
endmodule

// File: rtl/hostlink_rx.sv
// Receiver: start confirmed at half a bit, data and stop sampled mid-bit.
module hostlink_rx
   import hostlink_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int OSR   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_i,    // polarity-corrected, idle 1
   input  logic [DIV_W-1:0] div_i,
   output logic [7:0]       data_o,
   output logic             done_o,
   output logic             brk_o
);
   localparam int CW  = $clog2(OSR);
   localparam int MID = OSR / 2;

   rx_state_e        st_q;
   logic [DIV_W-1:0] div_q;
   logic [CW-1:0]    cnt_q;
   logic [2:0]       nbit_q;
   logic [7:0]       sh_q;
   logic             tick;

   hostlink_tick #(.DIV_W(DIV_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (st_q == RX_IDLE || st_q == RX_HOLD),
      .div_i  (div_q),
      .tick_o (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= RX_IDLE;
         div_q  <= '1;
         cnt_q  <= '0;
         nbit_q <= '0;
         sh_q   <= '0;
         data_o <= '0;
         done_o <= 1'b0;
         brk_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         brk_o  <= 1'b0;
         case (st_q)
            RX_IDLE: begin
               if (!line_i) begin
                  st_q  <= RX_START;
                  div_q <= div_i;       // rate fixed for this character
                  cnt_q <= '0;
               end
            end
            RX_START: begin
               if (tick) begin
                  if (cnt_q == CW'(MID - 1)) begin
                     cnt_q  <= '0;
                     nbit_q <= '0;
                     st_q   <= line_i ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            RX_DATA: begin
               if (tick) begin
                  if (cnt_q == CW'(OSR - 1)) begin
                     cnt_q <= '0;
                     sh_q  <= {line_i, sh_q[7:1]};
                     if (nbit_q == 3'd7) st_q <= RX_STOP;
                     nbit_q <= nbit_q + 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            RX_STOP: begin
               if (tick) begin
                  if (cnt_q == CW'(OSR - 1)) begin
                     cnt_q <= '0;
                     if (line_i) begin
                        data_o <= sh_q;
                        done_o <= 1'b1;
                        st_q   <= RX_IDLE;
                     end else begin
                        brk_o  <= 1'b1;
                        st_q   <= RX_HOLD;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            RX_HOLD: begin
               if (line_i) st_q <= RX_IDLE;   // wait for break to end
            end
            default: st_q <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hostlink_tx.sv
// Transmitter: start, 8 data bits LSB first, one stop bit.
module hostlink_tx
   import hostlink_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int OSR   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic [7:0]       data_i,
   input  logic             valid_i,
   output logic             ready_o,
   output logic             bit_o      // idle 1, before polarity
);
   localparam int CW = $clog2(OSR);
   localparam int FW = 10;

   tx_state_e        st_q;
   logic [DIV_W-1:0] div_q;
   logic [CW-1:0]    cnt_q;
   logic [3:0]       nbit_q;
   logic [FW-1:0]    sh_q;
   logic             tick;

   assign ready_o = (st_q == TX_IDLE);
   assign bit_o   = (st_q == TX_SEND) ? sh_q[0] : 1'b1;

   hostlink_tick #(.DIV_W(DIV_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (st_q == TX_IDLE),
      .div_i  (div_q),
      .tick_o (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= TX_IDLE;
         div_q  <= '1;
         cnt_q  <= '0;
         nbit_q <= '0;
         sh_q   <= '1;
      end else if (abort_i) begin
         st_q   <= TX_IDLE;
         sh_q   <= '1;
      end else begin
         case (st_q)
            TX_IDLE: begin
               if (valid_i) begin
                  st_q   <= TX_SEND;
                  div_q  <= div_i;
                  cnt_q  <= '0;
                  nbit_q <= '0;
                  sh_q   <= {1'b1, data_i, 1'b0};
               end
            end
            TX_SEND: begin
               if (tick) begin
                  if (cnt_q == CW'(OSR - 1)) begin
                     cnt_q <= '0;
                     sh_q  <= {1'b1, sh_q[FW-1:1]};
                     if (nbit_q == 4'(FW - 1)) st_q <= TX_IDLE;
                     nbit_q <= nbit_q + 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: st_q <= TX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hostlink_uart.sv
module hostlink_uart
   import hostlink_pkg::*;
#(
   parameter int CLK_HZ      = 18_432_000,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pol_strap,
   input  logic       host_tx_line,
   output logic       host_rx_line,
   input  logic       cfg_we,
   input  logic [1:0] cfg_rate,
   input  logic       cfg_txinv,
   output logic [7:0] rx_byte,
   output logic       rx_strobe,
   input  logic [7:0] tx_byte,
   input  logic       tx_valid,
   output logic       tx_ready,
   output logic       mreset_pulse
);
   localparam int NRATES  = 4;
   localparam int DIV_MAX = CLK_HZ / (OSR * int'(rate_bps(0)));
   localparam int DIV_W   = $clog2(DIV_MAX + 1);

   // elaboration checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
      $error("OSR must be even and at least 4");
   end

   // divisor per speed code
   logic [DIV_W-1:0] div_tab [NRATES];
   for (genvar g = 0; g < NRATES; g++) begin : g_div
      localparam int D = CLK_HZ / (OSR * int'(rate_bps(g)));
      if (D < 1) begin : g_bad_div
         $error("clock too slow for selected oversampling");
      end
      assign div_tab[g] = DIV_W'(D);
   end

   // input synchroniser
   logic [SYNC_STAGES-1:0] sync_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], host_tx_line};
   end

   logic rx_bit;
   assign rx_bit = sync_q[SYNC_STAGES-1] ^ ~pol_strap;

   // configuration and calibration state
   logic [1:0] rate_q;
   logic       inv_q;
   logic       calib_q;
   logic       rx_done, rx_brk, tx_bit;
   logic [DIV_W-1:0] div_cur;

   assign div_cur = div_tab[rate_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q  <= RATE_9K6;
         inv_q   <= 1'b0;
         calib_q <= 1'b1;
      end else if (rx_brk) begin
         rate_q  <= RATE_9K6;
         inv_q   <= 1'b0;
         calib_q <= 1'b1;
      end else begin
         if (cfg_we) begin
            rate_q <= cfg_rate;
            inv_q  <= cfg_txinv;
         end
         if (rx_done) calib_q <= 1'b0;
      end
   end

   hostlink_rx #(.DIV_W(DIV_W), .OSR(OSR)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (rx_bit),
      .div_i  (div_cur),
      .data_o (rx_byte),
      .done_o (rx_done),
      .brk_o  (rx_brk)
   );

   hostlink_tx #(.DIV_W(DIV_W), .OSR(OSR)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .abort_i (rx_brk),
      .div_i   (div_cur),
      .data_i  (tx_byte),
      .valid_i (tx_valid),
      .ready_o (tx_ready),
      .bit_o   (tx_bit)
   );

   assign rx_strobe    = rx_done && !calib_q;
   assign mreset_pulse = rx_brk;
   assign host_rx_line = tx_bit ^ ~pol_strap ^ inv_q;

endmodule

// File: rtl/hostlink_uart_chk.sv
module hostlink_uart_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pol_strap,
   input logic       host_rx_line,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic       rx_strobe,
   input logic       mreset_pulse,
   input logic [1:0] rate_q,
   input logic       inv_q,
   input logic       calib_q
);
   // R12: an accepted request makes the transmitter busy
   p_accept_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_ready);

   // R4 / R5: idle outgoing level follows strap and invert bit
   p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> (host_rx_line == (pol_strap ^ inv_q)));

   // R6: master reset request lasts one clock
   p_mreset_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mreset_pulse |=> !mreset_pulse);

   // R8: master reset restores default rate and polarity, re-arms calibration
   p_mreset_defaults_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mreset_pulse |=> (rate_q == 2'd0 && !inv_q && calib_q));

   // R1: one strobe per character
   p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |=> !rx_strobe);

   // R9: no character delivered right after a master reset
   p_no_strobe_after_mreset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mreset_pulse |=> !rx_strobe);
endmodule

bind hostlink_uart hostlink_uart_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pol_strap    (pol_strap),
   .host_rx_line (host_rx_line),
   .tx_valid     (tx_valid),
   .tx_ready     (tx_ready),
   .rx_strobe    (rx_strobe),
   .mreset_pulse (mreset_pulse),
   .rate_q       (rate_q),
   .inv_q        (inv_q),
   .calib_q      (calib_q)
);

// File: tb/hostlink_uart_test.sv
module hostlink_uart_test;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_HZ     = 1_843_200;   // divisors 12, 6, 2, 1

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pol_strap = 1'b1;
   logic       host_tx_line = 1'b1;
   logic       host_rx_line;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_rate = 2'd0;
   logic       cfg_txinv = 1'b0;
   logic [7:0] rx_byte;
   logic       rx_strobe;
   logic [7:0] tx_byte = 8'h00;
   logic       tx_valid = 1'b0;
   logic       tx_ready;
   logic       mreset_pulse;

   int n_tests = 0;
   int n_fail  = 0;
   int n_rx    = 0;
   int n_mr    = 0;
   logic [7:0] last_rx = 8'h00;
   logic bench_inv = 1'b0;

   hostlink_uart #(.CLK_HZ(CLK_HZ)) uut (
      .clk(clk), .rst_n(rst_n), .pol_strap(pol_strap),
      .host_tx_line(host_tx_line), .host_rx_line(host_rx_line),
      .cfg_we(cfg_we), .cfg_rate(cfg_rate), .cfg_txinv(cfg_txinv),
      .rx_byte(rx_byte), .rx_strobe(rx_strobe),
      .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .mreset_pulse(mreset_pulse)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      if (rx_strobe) begin
         n_rx++;
         last_rx = rx_byte;
      end
      if (mreset_pulse) n_mr++;
   end

   function automatic int bit_cycles(input int code);
      case (code)
         0:       return 192;
         1:       return 96;
         2:       return 32;
         default: return 16;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic set_line(input logic b);
      host_tx_line = pol_strap ? b : ~b;
   endtask

   task automatic cfg_write(input int code, input logic inv);
      @(negedge clk);
      cfg_we = 1'b1; cfg_rate = 2'(code); cfg_txinv = inv;
      @(negedge clk);
      cfg_we = 1'b0;
      bench_inv = inv;
   endtask

   task automatic send_char(input logic [7:0] v, input int bc, input int stops);
      logic [9:0] f;
      f = {1'b1, v, 1'b0};
      @(negedge clk);
      for (int k = 0; k < 10; k++) begin
         set_line(f[k]);
         repeat (bc) @(negedge clk);
      end
      if (stops > 1) repeat (bc) @(negedge clk);
   endtask

   task automatic rx_expect(input logic [7:0] v, input int bc, input int stops,
                            input string req);
      int n0;
      n0 = n_rx;
      send_char(v, bc, stops);
      check(n_rx == n0 + 1, req, "strobe count", n_rx - n0, 1);
      check(last_rx == v, req, "received byte", last_rx, v);
   endtask

   // transmit one frame and check every bit mid-way; optional config change at bit 4
   task automatic tx_frame(input logic [7:0] v, input int bc, input int chg,
                           input string req);
      logic [9:0] f;
      logic lvl;
      f   = {1'b1, v, 1'b0};
      lvl = pol_strap ^ bench_inv;
      @(negedge clk);
      tx_byte = v; tx_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tx_valid = 1'b0;
      repeat (bc/2 - 1) @(negedge clk);
      for (int k = 0; k < 10; k++) begin
         check(host_rx_line == (f[k] ^ ~lvl), req, $sformatf("frame bit %0d", k),
               host_rx_line, f[k] ^ ~lvl);
         if (k == 9) check(tx_ready == 1'b0, req, "busy in stop bit", tx_ready, 0);
         if (k == 4 && chg >= 0) begin
            cfg_write(chg, bench_inv);
            repeat (bc - 2) @(negedge clk);
         end else begin
            repeat (bc) @(negedge clk);
         end
      end
      check(tx_ready == 1'b1, req, "ready after one stop bit", tx_ready, 1);
   endtask

   task automatic t_reset;
      check(tx_ready == 1'b1, "R8", "ready after reset", tx_ready, 1);
      check(host_rx_line == 1'b1, "R8", "idle line after reset", host_rx_line, 1);
      check(n_mr == 0, "R6", "no master reset", n_mr, 0);
   endtask

   task automatic t_calibration;
      int n0;
      n0 = n_rx;
      send_char(8'h55, bit_cycles(0), 1);
      check(n_rx == n0, "R9", "calibration char swallowed", n_rx - n0, 0);
      rx_expect(8'hA3, bit_cycles(0), 1, "R1");
      rx_expect(8'h01, bit_cycles(0), 1, "R8");
   endtask

   task automatic t_two_stop;
      rx_expect(8'h0F, bit_cycles(0), 2, "R2");
      rx_expect(8'hF0, bit_cycles(0), 2, "R2");
   endtask

   task automatic t_glitch;
      int n0;
      n0 = n_rx;
      @(negedge clk);
      set_line(1'b0);
      repeat (40) @(negedge clk);
      set_line(1'b1);
      repeat (2 * bit_cycles(0)) @(negedge clk);
      check(n_rx == n0, "R10", "short low pulse ignored", n_rx - n0, 0);
      rx_expect(8'h5A, bit_cycles(0), 1, "R10");
   endtask

   task automatic t_handshake;
      int bad;
      bad = 0;
      tx_frame(8'h96, bit_cycles(0), -1, "R3");
      @(negedge clk);
      tx_byte = 8'h3C; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      repeat (3 * bit_cycles(0)) @(negedge clk);
      @(negedge clk);
      tx_byte = 8'h00; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      check(tx_ready == 1'b0, "R12", "busy during frame", tx_ready, 0);
      repeat (8 * bit_cycles(0)) @(negedge clk);
      for (int i = 0; i < 48; i++) begin
         if (host_rx_line != 1'b1) bad++;
         repeat (8) @(negedge clk);
      end
      check(bad == 0, "R12", "no second frame from busy request", bad, 0);
      check(tx_ready == 1'b1, "R12", "ready after frame", tx_ready, 1);
   endtask

   task automatic t_rates;
      for (int c = 1; c < 4; c++) begin
         cfg_write(c, 1'b0);
         rx_expect(8'hC5 ^ 8'(c), bit_cycles(c), 1, "R7");
         tx_frame(8'h6B ^ 8'(c), bit_cycles(c), -1, "R7");
      end
      cfg_write(0, 1'b0);
   endtask

   task automatic t_mid_change;
      tx_frame(8'hE1, bit_cycles(0), 1, "R11");
      tx_frame(8'h1E, bit_cycles(1), -1, "R11");
      cfg_write(0, 1'b0);
   endtask

   task automatic t_tx_invert;
      cfg_write(0, 1'b1);
      repeat (4) @(negedge clk);
      check(host_rx_line == 1'b0, "R5", "inverted idle level", host_rx_line, 0);
      tx_frame(8'hB2, bit_cycles(0), -1, "R5");
      rx_expect(8'h4D, bit_cycles(0), 1, "R5");
      cfg_write(0, 1'b0);
   endtask

   task automatic t_strap;
      @(negedge clk);
      pol_strap = 1'b0;
      set_line(1'b1);
      repeat (2 * bit_cycles(0)) @(negedge clk);
      check(host_rx_line == 1'b0, "R4", "idle low with strap 0", host_rx_line, 0);
      rx_expect(8'h27, bit_cycles(0), 1, "R4");
      tx_frame(8'hD4, bit_cycles(0), -1, "R4");
      @(negedge clk);
      pol_strap = 1'b1;
      set_line(1'b1);
      repeat (2 * bit_cycles(0)) @(negedge clk);
   endtask

   task automatic t_break;
      int m0, n0;
      cfg_write(2, 1'b1);
      m0 = n_mr;
      @(negedge clk);
      set_line(1'b0);
      repeat (20 * bit_cycles(2)) @(negedge clk);
      set_line(1'b1);
      repeat (2 * bit_cycles(0)) @(negedge clk);
      bench_inv = 1'b0;
      check(n_mr == m0 + 1, "R6", "one-cycle master reset", n_mr - m0, 1);
      check(host_rx_line == 1'b1, "R6", "invert cleared", host_rx_line, 1);
      n0 = n_rx;
      send_char(8'h77, bit_cycles(0), 1);
      check(n_rx == n0, "R9", "calibration after master reset", n_rx - n0, 0);
      rx_expect(8'h88, bit_cycles(0), 1, "R8");
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_calibration();
      t_two_stop();
      t_glitch();
      t_handshake();
      t_rates();
      t_mid_change();
      t_tx_invert();
      t_strap();
      t_break();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 180000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule